// File: doc/BRIEF.md
# Masked Program-Counter Breakpoint Trigger

This block watches the program counter of a processor core and raises a trigger when a sampled PC value matches a programmed breakpoint address. The comparison is masked bit by bit: a set bit in the mask register removes that bit position from the compare, so one breakpoint can cover an aligned range or a scattered set of addresses. A PC sample only counts when its valid strobe is high.

Software sets up the unit through an indexed, write-only debug register port. It holds three registers: the breakpoint address, the mask, and a trigger definition word. That word enables the compare for a first and a second trigger level and selects one-level or two-level sequencing. In two-level mode, a first matching PC arms the unit and a later match fires the trigger. The port accepts writes only while the core reports supervisor mode. The trigger output is a registered single-cycle pulse that a debug controller consumes.

Top module: `pc_bkpt_trigger`

## Requirements
- R1: The breakpoint address register is written at index 0x08, resets to zero, and holds the value the PC is compared against.
- R2: For each bit position, a mask bit of 0 requires the PC bit to equal the address bit, and a mask bit of 1 excludes that position from the compare.
- R3: The mask register is written at index 0x09 and resets to zero, which means full compare.
- R4: The trigger definition register is written at index 0x07 and resets to zero. Bit 0 enables the first level. Bit 16 enables the second level. Bit 31 selects two-level mode when it is 1. All other bits are ignored.
- R5: A register write while `sup_mode` is low has no effect on any register.
- R6: A write to any index other than 0x07, 0x08 or 0x09 has no effect on any register.
- R7: A PC sample takes part in a compare only when `pc_valid` is high.
- R8: `trig_o` is high for exactly the one cycle after each clock edge at which a qualifying hit was sampled.
- R9: In one-level mode, a hit fires when bit 0 is set; bit 16 has no effect.
- R10: In two-level mode with both levels enabled, the first hit only arms the unit, the next hit fires, and firing disarms the unit.
- R11: Any accepted write to the trigger definition register disarms the unit.
- R12: In two-level mode with bit 16 clear, hits arm the unit but never fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pc | input | 32 | Program counter sample |
| pc_valid | input | 1 | Qualifies `pc` for this cycle |
| sup_mode | input | 1 | Core is in supervisor mode; gates register writes |
| wr_en | input | 1 | Debug register write strobe |
| wr_idx | input | 5 | Debug register index |
| wr_data | input | 32 | Debug register write data |
| trig_o | output | 1 | Breakpoint trigger pulse |

## Verification
The registers cannot be read back, so every internal state shows only through `trig_o`. A wrong address or mask bit turns a hit into a miss, or a miss into a hit, on the very next qualifying PC sample. The bench therefore probes each write with PC values that sit on both sides of the changed bits. A stuck or missing arm flag in two-level mode shows as a trigger on the first hit, or no trigger on the second hit, one cycle after the sample. That makes the order of hits the key stimulus.

// File: rtl/pcbk_pkg.sv
// Package pcbk_pkg
// Purpose : shared constants and types for the masked PC breakpoint unit.
// Assumes : index values are fixed by the debug register map of the core.
package pcbk_pkg;

    localparam int unsigned IDX_W = 5;

    localparam logic [IDX_W-1:0] IDX_TDEF = 5'h07;
    localparam logic [IDX_W-1:0] IDX_ADDR = 5'h08;
    localparam logic [IDX_W-1:0] IDX_MASK = 5'h09;

    // Bit positions inside the 32-bit trigger definition word.
    localparam int unsigned TDEF_L1_EN_BIT  = 0;
    localparam int unsigned TDEF_L2_EN_BIT  = 16;
    localparam int unsigned TDEF_TWO_LV_BIT = 31;

    // Only the bits that carry meaning are kept.
    typedef struct packed {
        logic two_level;
        logic l2_en;
        logic l1_en;
    } tdef_t;

    // Decoded write target.
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_TDEF = 2'd1,
        SEL_ADDR = 2'd2,
        SEL_MASK = 2'd3
    } wsel_e;

endpackage

// File: rtl/pcbk_regs.sv
// Module  : pcbk_regs
// Purpose : write-only register file holding breakpoint address, mask and
//           trigger definition; decodes the indexed debug write port.
// Assumes : writes are accepted only in supervisor mode; unknown indices are
//           dropped; all registers reset to zero.
module pcbk_regs
    import pcbk_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sup_mode,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    addr_q,
    output logic [DW-1:0]    mask_q,
    output tdef_t            tdef_q,
    output logic             tdef_wr
);

    wsel_e sel;
    logic  accept;

    // Decode the index into a write target.
    always_comb begin
        unique case (wr_idx)
            IDX_TDEF: sel = SEL_TDEF;
            IDX_ADDR: sel = SEL_ADDR;
            IDX_MASK: sel = SEL_MASK;
            default:  sel = SEL_NONE;
        endcase
    end

    // A write counts only from supervisor mode and to a known index.
    assign accept  = wr_en && sup_mode && (sel != SEL_NONE);
    assign tdef_wr = accept && (sel == SEL_TDEF);

    // Breakpoint address register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (accept && sel == SEL_ADDR)
            addr_q <= wr_data;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (accept && sel == SEL_MASK)
            mask_q <= wr_data;
    end

    // Trigger definition register, meaningful bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tdef_q <= '0;
        else if (tdef_wr) begin
            tdef_q.l1_en     <= wr_data[TDEF_L1_EN_BIT];
            tdef_q.l2_en     <= wr_data[TDEF_L2_EN_BIT];
            tdef_q.two_level <= wr_data[TDEF_TWO_LV_BIT];
        end
    end

    AST_USER_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !sup_mode) |=> ($stable(addr_q) && $stable(mask_q) && $stable(tdef_q))); // R5

    AST_UNKNOWN_IDX_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx != IDX_TDEF && wr_idx != IDX_ADDR && wr_idx != IDX_MASK)
        |=> ($stable(addr_q) && $stable(mask_q) && $stable(tdef_q))); // R6

    AST_ADDR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sup_mode && wr_idx == IDX_ADDR) |=> (addr_q == $past(wr_data))); // R1

endmodule

// File: rtl/pcbk_match.sv
// Module  : pcbk_match
// Purpose : combinational masked comparison of the PC against the address.
// Assumes : a set mask bit excludes that bit position; the result is
//           qualified by the PC valid strobe.
module pcbk_match #(
    parameter int unsigned DW = 32
) (
    input  logic [DW-1:0] pc,
    input  logic          pc_valid,
    input  logic [DW-1:0] addr,
    input  logic [DW-1:0] mask,
    output logic          hit
);

    logic [DW-1:0] diff_bits;

    // Per-bit mismatch, with masked positions forced to agree.
    genvar gi;
    generate
        for (gi = 0; gi < DW; gi++) begin : g_bit
            assign diff_bits[gi] = (pc[gi] ^ addr[gi]) & ~mask[gi];
        end
    endgenerate

    // A hit needs a valid sample and no unmasked mismatch.
    assign hit = pc_valid && (diff_bits == '0);

    always_comb begin
        if (!pc_valid)
            AST_NO_HIT_WITHOUT_VALID: assert (!hit); // R7
    end

endmodule

// File: rtl/pcbk_seq.sv
// Module  : pcbk_seq
// Purpose : one- or two-level trigger sequencer producing a registered
//           single-cycle trigger pulse per qualifying hit.
// Assumes : a trigger definition write disarms; in two-level mode the first
//           hit arms, the next hit fires and disarms.
module pcbk_seq
    import pcbk_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  hit,
    input  tdef_t tdef,
    input  logic  tdef_wr,
    output logic  trig_o
);

    logic armed_q;
    logic arm_set;
    logic fire;

    // Decide whether this cycle's hit fires or arms.
    always_comb begin
        fire    = 1'b0;
        arm_set = 1'b0;
        if (!tdef.two_level) begin
            fire = hit && tdef.l1_en;
        end else if (!armed_q) begin
            arm_set = hit && tdef.l1_en;
        end else begin
            fire = hit && tdef.l2_en;
        end
    end

    // Arm flag: cleared on definition write or after firing.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b0;
        else if (tdef_wr)
            armed_q <= 1'b0;
        else if (arm_set)
            armed_q <= 1'b1;
        else if (fire && tdef.two_level)
            armed_q <= 1'b0;
    end

    // Registered trigger pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            trig_o <= 1'b0;
        else
            trig_o <= fire;
    end

    AST_DEF_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        tdef_wr |=> !armed_q); // R11

    AST_TWO_LEVEL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_o && $past(tdef.two_level)) |-> $past(armed_q)); // R10

    AST_NO_FIRE_L2_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (tdef.two_level && !tdef.l2_en) |=> !trig_o); // R12

    AST_ONE_LEVEL_NEEDS_L1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tdef.two_level && !tdef.l1_en) |=> !trig_o); // R9

endmodule

// File: rtl/pc_bkpt_trigger.sv
// Module  : pc_bkpt_trigger
// Purpose : masked PC breakpoint trigger unit; top level joining register
//           file, comparator and sequencer.
// Assumes : synchronous active-low reset; register port is write-only.
module pc_bkpt_trigger
    import pcbk_pkg::*;
#(
    parameter int unsigned DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DW-1:0]    pc,
    input  logic             pc_valid,
    input  logic             sup_mode,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    output logic             trig_o
);

    logic [DW-1:0] addr_q;
    logic [DW-1:0] mask_q;
    tdef_t         tdef_q;
    logic          tdef_wr;
    logic          hit;

    pcbk_regs #(.DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sup_mode(sup_mode),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .addr_q  (addr_q),
        .mask_q  (mask_q),
        .tdef_q  (tdef_q),
        .tdef_wr (tdef_wr)
    );

    pcbk_match #(.DW(DW)) u_match (
        .pc      (pc),
        .pc_valid(pc_valid),
        .addr    (addr_q),
        .mask    (mask_q),
        .hit     (hit)
    );

    pcbk_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (hit),
        .tdef   (tdef_q),
        .tdef_wr(tdef_wr),
        .trig_o (trig_o)
    );

    AST_TRIG_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> $past(pc_valid)); // R8

    AST_TRIG_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> ((($past(pc) ^ $past(addr_q)) & ~$past(mask_q)) == '0)); // R2

endmodule

// File: tb/pc_bkpt_trigger_tb.sv
// Directed bench for pc_bkpt_trigger: one task per scenario.
module pc_bkpt_trigger_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pc = '0;
    logic        pc_valid = 1'b0;
    logic        sup_mode = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        trig_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    pc_bkpt_trigger u_dut (
        .clk(clk), .rst_n(rst_n), .pc(pc), .pc_valid(pc_valid),
        .sup_mode(sup_mode), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .trig_o(trig_o)
    );

    task automatic check(input string req, input logic exp);
        n_checks++;
        if (trig_o !== exp) begin
            n_errors++;
            $display("FAIL %s: trig_o=%b expected %b at %0t", req, trig_o, exp, $time);
        end
    endtask

    // Register write applied over one clock edge; inputs change at negedge.
    task automatic wreg(input logic [4:0] idx, input logic [31:0] d, input logic sup);
        wr_en = 1'b1; wr_idx = idx; wr_data = d; sup_mode = sup;
        @(negedge clk);
        wr_en = 1'b0; sup_mode = 1'b1;
    endtask

    // Present one PC sample, then check trig_o one edge later.
    task automatic sample(input logic [31:0] p, input logic v, input string req, input logic exp);
        pc = p; pc_valid = v;
        @(negedge clk);
        pc_valid = 1'b0;
        check(req, exp);
    endtask

    task automatic t_reset;
        sample(32'h0, 1'b1, "R4 reset disables trigger", 1'b0);
        wreg(5'h07, 32'h0000_0001, 1'b1);
        sample(32'h0, 1'b1, "R1 address resets to zero", 1'b1);
        sample(32'h4, 1'b1, "R3 mask resets to zero", 1'b0);
    endtask

    task automatic t_exact;
        wreg(5'h08, 32'h1000_2000, 1'b1);
        sample(32'h1000_2000, 1'b1, "R1 exact match", 1'b1);
        check("R8 pulse lasts one cycle", 1'b1);
        @(negedge clk);
        check("R8 pulse ends", 1'b0);
        sample(32'h1000_2001, 1'b1, "R2 unmasked bit differs", 1'b0);
        sample(32'h1000_2000, 1'b0, "R7 invalid sample ignored", 1'b0);
    endtask

    task automatic t_mask;
        wreg(5'h09, 32'h0000_00FF, 1'b1);
        sample(32'h1000_20AB, 1'b1, "R2 masked bits ignored", 1'b1);
        sample(32'h1000_2100, 1'b1, "R3 unmasked bit checked", 1'b0);
        pc = 32'h1000_2000; pc_valid = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R8 one pulse per hit, back to back", 1'b1);
        pc_valid = 1'b0;
        @(negedge clk);
        check("R8 back-to-back ends", 1'b0);
    endtask

    task automatic t_ignored_writes;
        wreg(5'h08, 32'hDEAD_0000, 1'b0);
        sample(32'h1000_2000, 1'b1, "R5 user-mode write dropped", 1'b1);
        wreg(5'h09, 32'hFFFF_FFFF, 1'b0);
        sample(32'h2000_0000, 1'b1, "R5 user-mode mask write dropped", 1'b0);
        wreg(5'h0A, 32'hFFFF_FFFF, 1'b1);
        sample(32'h2000_0000, 1'b1, "R6 unknown index dropped", 1'b0);
        wreg(5'h07, 32'h0000_0000, 1'b0);
        sample(32'h1000_2000, 1'b1, "R5 user-mode definition write dropped", 1'b1);
    endtask

    task automatic t_one_level_l2_only;
        wreg(5'h07, 32'h0001_0000, 1'b1);
        sample(32'h1000_2000, 1'b1, "R9 bit16 alone does not fire", 1'b0);
        wreg(5'h07, 32'h7FFE_0001, 1'b1);
        sample(32'h1000_2000, 1'b1, "R4 other bits ignored, one-level fires", 1'b1);
    endtask

    task automatic t_two_level;
        wreg(5'h07, 32'h8001_0001, 1'b1);
        sample(32'h1000_2000, 1'b1, "R10 first hit only arms", 1'b0);
        sample(32'h3000_0000, 1'b1, "R10 miss keeps armed, no fire", 1'b0);
        sample(32'h1000_2000, 1'b1, "R10 second hit fires", 1'b1);
        sample(32'h1000_2000, 1'b1, "R10 fire disarms", 1'b0);
        sample(32'h1000_2000, 1'b1, "R10 re-armed hit fires", 1'b1);
    endtask

    task automatic t_disarm;
        sample(32'h1000_2000, 1'b1, "R11 arm before write", 1'b0);
        wreg(5'h07, 32'h8001_0001, 1'b1);
        sample(32'h1000_2000, 1'b1, "R11 write disarmed", 1'b0);
        sample(32'h1000_2000, 1'b1, "R11 fires after re-arm", 1'b1);
    endtask

    task automatic t_l2_off;
        wreg(5'h07, 32'h8000_0001, 1'b1);
        sample(32'h1000_2000, 1'b1, "R12 first hit", 1'b0);
        sample(32'h1000_2000, 1'b1, "R12 second hit no fire", 1'b0);
        sample(32'h1000_2000, 1'b1, "R12 third hit no fire", 1'b0);
    endtask

    initial begin
        fork
            begin
                repeat (4) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_exact();
                t_mask();
                t_ignored_writes();
                t_one_level_l2_only();
                t_two_level();
                t_disarm();
                t_l2_off();
            end
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: run did not finish, expected completion");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule